// File: doc/BRIEF.md
# Base-Integer Subset Instruction Decoder

This block is a purely combinational decoder for sixteen instructions of the 32-bit RISC-V base integer encoding. It covers the two jumps, the five loads, the three stores and six register-immediate ALU operations. A 32-bit instruction word comes in. The block returns a 4-bit operation code, the three register index fields and a 32-bit sign-extended immediate, all in the same cycle.

The immediate follows the format that the decoded operation uses. I-type comes from the upper twelve bits. S-type joins the two split fields. J-type gathers its scattered bits into a 21-bit even byte offset. Any word outside the subset raises an illegal flag. A cause bit says whether the major opcode was unknown or the opcode was known but its funct3 selector was not. Branches, upper-immediate forms, register-register arithmetic, shifts and system instructions all fall into the unknown-opcode class.

Top module: `rv32i_subset_decoder`

## Requirements
- R1: `rd_o` is instr[11:7], `rs1_o` is instr[19:15] and `rs2_o` is instr[24:20], for every input word, legal or not.
- R2: opcode 1101111 decodes as JAL, op code 0, whatever funct3 holds.
- R3: opcode 1100111 decodes as JALR (op 1) only with funct3 000; any other funct3 is illegal with cause 1.
- R4: opcode 0000011 decodes funct3 000/001/010/100/101 as LB/LH/LW/LBU/LHU (op 2/3/4/5/6); funct3 011, 110 and 111 are illegal with cause 1.
- R5: opcode 0100011 decodes funct3 000/001/010 as SB/SH/SW (op 7/8/9); other funct3 values are illegal with cause 1.
- R6: opcode 0010011 decodes funct3 000/010/011/100/110/111 as ADDI/SLTI/SLTIU/XORI/ORI/ANDI (op 10..15); funct3 001 and 101 are illegal with cause 1.
- R7: any other opcode, including one whose two low bits are not 11, is illegal with cause 0.
- R8: for JALR, loads and OP-IMM, `imm_o` is instr[31:20] sign-extended from bit 31.
- R9: for stores, `imm_o` is {instr[31:25], instr[11:7]} sign-extended from bit 31.
- R10: for JAL, `imm_o` is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended from bit 31, so bit 0 is always 0.
- R11: whenever `illegal_o` is 1, `imm_o` is 0. `op_o` carries no meaning in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| op_o | output | 4 | Operation code (0 JAL .. 15 ANDI), meaningful only when legal |
| rd_o | output | 5 | Destination register field |
| rs1_o | output | 5 | First source register field |
| rs2_o | output | 5 | Second source register field |
| imm_o | output | 32 | Sign-extended immediate for the decoded format |
| illegal_o | output | 1 | Word is outside the supported subset |
| illegal_cause_o | output | 1 | 0 = unknown opcode, 1 = unknown funct3 for a known opcode |

## Verification
The bench targets the funct3 holes inside each known opcode: JALR with 001, loads with 011/110/111, stores with 011, and OP-IMM with 001/101. A decoder with an incomplete case table would accept these as a neighbouring instruction, or would report them as an opcode fault. Immediates are driven with negative values and with single isolated bits. A J-immediate with permuted pieces then lands at the wrong power of two, and a missing sign extension leaves the upper bits clear. Opcodes that differ from a legal one only in their low two bits, and whole families outside the subset, check that no near-miss is decoded.

// File: rtl/rvd_pkg.sv
package rvd_pkg;
  localparam int ILEN  = 32;
  localparam int REG_W = 5;
  localparam int OPC_W = 7;
  localparam int F3_W  = 3;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_JAL, OP_JALR, OP_LB, OP_LH, OP_LW, OP_LBU, OP_LHU,
    OP_SB, OP_SH, OP_SW, OP_ADDI, OP_SLTI, OP_SLTIU, OP_XORI, OP_ORI, OP_ANDI
  } op_e;

  typedef enum logic [1:0] {FMT_NONE, FMT_I, FMT_S, FMT_J} fmt_e;

  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;

  localparam logic CAUSE_OPCODE = 1'b0;
  localparam logic CAUSE_FUNCT3 = 1'b1;
endpackage

// File: rtl/rvd_fields.sv
module rvd_fields
  import rvd_pkg::*;
#(
  parameter int IW = ILEN,
  parameter int RW = REG_W
) (
  input  logic [IW-1:0]    instr_i,
  output logic [OPC_W-1:0] opcode_o,
  output logic [F3_W-1:0]  funct3_o,
  output logic [RW-1:0]    rd_o,
  output logic [RW-1:0]    rs1_o,
  output logic [RW-1:0]    rs2_o
);
  localparam int RD_LO  = OPC_W;
  localparam int F3_LO  = RD_LO + RW;
  localparam int RS1_LO = F3_LO + F3_W;
  localparam int RS2_LO = RS1_LO + RW;

  assign opcode_o = instr_i[OPC_W-1:0];
  assign rd_o     = instr_i[RD_LO +: RW];
  assign funct3_o = instr_i[F3_LO +: F3_W];
  assign rs1_o    = instr_i[RS1_LO +: RW];
  assign rs2_o    = instr_i[RS2_LO +: RW];

  logic unused_hi;
  assign unused_hi = ^instr_i[IW-1:RS2_LO+RW];
endmodule

// File: rtl/rvd_op_dec.sv
module rvd_op_dec
  import rvd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  output op_e              op_o,
  output fmt_e             fmt_o,
  output logic             illegal_o,
  output logic             cause_o
);
  always_comb begin
    op_o      = OP_JAL;
    fmt_o     = FMT_NONE;
    illegal_o = 1'b0;
    cause_o   = CAUSE_OPCODE;
    unique case (opcode_i)
      OPC_JAL: begin
        op_o  = OP_JAL;
        fmt_o = FMT_J;
      end
      OPC_JALR: begin
        fmt_o = FMT_I;
        if (funct3_i == 3'b000) op_o = OP_JALR;
        else illegal_o = 1'b1;
      end
      OPC_LOAD: begin
        fmt_o = FMT_I;
        case (funct3_i)
          3'b000:  op_o = OP_LB;
          3'b001:  op_o = OP_LH;
          3'b010:  op_o = OP_LW;
          3'b100:  op_o = OP_LBU;
          3'b101:  op_o = OP_LHU;
          default: illegal_o = 1'b1;
        endcase
      end
      OPC_STORE: begin
        fmt_o = FMT_S;
        case (funct3_i)
          3'b000:  op_o = OP_SB;
          3'b001:  op_o = OP_SH;
          3'b010:  op_o = OP_SW;
          default: illegal_o = 1'b1;
        endcase
      end
      OPC_OPIMM: begin
        fmt_o = FMT_I;
        case (funct3_i)
          3'b000:  op_o = OP_ADDI;
          3'b010:  op_o = OP_SLTI;
          3'b011:  op_o = OP_SLTIU;
          3'b100:  op_o = OP_XORI;
          3'b110:  op_o = OP_ORI;
          3'b111:  op_o = OP_ANDI;
          default: illegal_o = 1'b1;
        endcase
      end
      default: illegal_o = 1'b1;
    endcase
    // known opcode with a bad selector: funct3 cause, no immediate
    if (illegal_o && fmt_o != FMT_NONE) begin
      cause_o = CAUSE_FUNCT3;
      fmt_o   = FMT_NONE;
    end
  end
endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
  import rvd_pkg::*;
#(
  parameter int IW = ILEN
) (
  input  logic [IW-1:OPC_W] instr_i,
  input  fmt_e              fmt_i,
  output logic [IW-1:0]     imm_o
);
  localparam int I_W = 12;
  localparam int J_W = 21;

  logic [IW-1:0] imm_i, imm_s, imm_j;

  assign imm_i = {{(IW-I_W){instr_i[IW-1]}}, instr_i[31:20]};
  assign imm_s = {{(IW-I_W){instr_i[IW-1]}}, instr_i[31:25], instr_i[11:7]};
  assign imm_j = {{(IW-J_W){instr_i[IW-1]}}, instr_i[31], instr_i[19:12],
                  instr_i[20], instr_i[30:21], 1'b0};

  always_comb begin
    unique case (fmt_i)
      FMT_I:   imm_o = imm_i;
      FMT_S:   imm_o = imm_s;
      FMT_J:   imm_o = imm_j;
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/rv32i_subset_decoder.sv
module rv32i_subset_decoder
  import rvd_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [3:0]  op_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [31:0] imm_o,
  output logic        illegal_o,
  output logic        illegal_cause_o
);
  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  op_e              op;
  fmt_e             fmt;

  rvd_fields #(.IW(ILEN), .RW(REG_W)) u_fields (
    .instr_i  (instr_i),
    .opcode_o (opcode),
    .funct3_o (funct3),
    .rd_o     (rd_o),
    .rs1_o    (rs1_o),
    .rs2_o    (rs2_o)
  );

  rvd_op_dec u_op_dec (
    .opcode_i  (opcode),
    .funct3_i  (funct3),
    .op_o      (op),
    .fmt_o     (fmt),
    .illegal_o (illegal_o),
    .cause_o   (illegal_cause_o)
  );

  rvd_imm_gen #(.IW(ILEN)) u_imm_gen (
    .instr_i (instr_i[ILEN-1:OPC_W]),
    .fmt_i   (fmt),
    .imm_o   (imm_o)
  );

  assign op_o = op;

  always_comb begin
    if (illegal_o) begin
      a_r11_imm_zero: assert (imm_o == '0);
    end
    if (opcode != OPC_JAL && opcode != OPC_JALR && opcode != OPC_LOAD &&
        opcode != OPC_STORE && opcode != OPC_OPIMM) begin
      a_r7_opcode_cause: assert (illegal_o && illegal_cause_o == CAUSE_OPCODE);
    end
    if (!illegal_o && op == OP_JAL) begin
      a_r10_j_even: assert (imm_o[0] == 1'b0 &&
                            (imm_o[31:20] == '0 || imm_o[31:20] == '1));
    end
    if (!illegal_o && fmt == FMT_I) begin
      a_r8_i_sext: assert (imm_o[31:11] == '0 || imm_o[31:11] == '1);
    end
    if (!illegal_o && op == OP_JALR) begin
      a_r3_jalr_f3: assert (funct3 == 3'b000);
    end
    if (!illegal_o && opcode == OPC_OPIMM) begin
      a_r6_no_shift: assert (funct3 != 3'b001 && funct3 != 3'b101);
    end
  end
endmodule

// File: tb/rv32i_subset_decoder_tb.sv
module rv32i_subset_decoder_tb;
  import rvd_pkg::*;

  localparam int WD_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr;
  logic [3:0]  op;
  logic [4:0]  rd, rs1, rs2;
  logic [31:0] imm;
  logic        ill, cause;

  rv32i_subset_decoder u_dut (
    .instr_i         (instr),
    .op_o            (op),
    .rd_o            (rd),
    .rs1_o           (rs1),
    .rs2_o           (rs2),
    .imm_o           (imm),
    .illegal_o       (ill),
    .illegal_cause_o (cause)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  op;
    logic        ill;
    logic        cause;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [31:0] imm;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{32'h008000EF, OP_JAL,   1'b0, 1'b0, 5'd1,  5'd0,  5'd8,  32'h00000008, 4'd2},  // R2
    '{32'hFFFFF06F, OP_JAL,   1'b0, 1'b0, 5'd0,  5'd31, 5'd31, 32'hFFFFFFFE, 4'd10}, // R10
    '{32'h0010006F, OP_JAL,   1'b0, 1'b0, 5'd0,  5'd0,  5'd1,  32'h00000800, 4'd10},
    '{32'h0000106F, OP_JAL,   1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00001000, 4'd10},
    '{32'h00008067, OP_JALR,  1'b0, 1'b0, 5'd0,  5'd1,  5'd0,  32'h00000000, 4'd3},  // R3
    '{32'hFFC10067, OP_JALR,  1'b0, 1'b0, 5'd0,  5'd2,  5'd28, 32'hFFFFFFFC, 4'd8},  // R8
    '{32'h00009067, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd1,  5'd0,  32'h00000000, 4'd3},
    '{32'h00410083, OP_LB,    1'b0, 1'b0, 5'd1,  5'd2,  5'd4,  32'h00000004, 4'd4},  // R4
    '{32'h00411083, OP_LH,    1'b0, 1'b0, 5'd1,  5'd2,  5'd4,  32'h00000004, 4'd4},
    '{32'h80012183, OP_LW,    1'b0, 1'b0, 5'd3,  5'd2,  5'd0,  32'hFFFFF800, 4'd8},
    '{32'h7FF14203, OP_LBU,   1'b0, 1'b0, 5'd4,  5'd2,  5'd31, 32'h000007FF, 4'd4},
    '{32'h00015003, OP_LHU,   1'b0, 1'b0, 5'd0,  5'd2,  5'd0,  32'h00000000, 4'd4},
    '{32'h00013003, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd2,  5'd0,  32'h00000000, 4'd4},
    '{32'h00016003, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd2,  5'd0,  32'h00000000, 4'd4},
    '{32'h00017003, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd2,  5'd0,  32'h00000000, 4'd4},
    '{32'h00208023, OP_SB,    1'b0, 1'b0, 5'd0,  5'd1,  5'd2,  32'h00000000, 4'd5},  // R5
    '{32'hFE209FA3, OP_SH,    1'b0, 1'b0, 5'd31, 5'd1,  5'd2,  32'hFFFFFFFF, 4'd9},  // R9
    '{32'h00112623, OP_SW,    1'b0, 1'b0, 5'd12, 5'd2,  5'd1,  32'h0000000C, 4'd9},
    '{32'h40000023, OP_SB,    1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000400, 4'd9},
    '{32'h00003023, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd5},
    '{32'h00500093, OP_ADDI,  1'b0, 1'b0, 5'd1,  5'd0,  5'd5,  32'h00000005, 4'd6},  // R6
    '{32'hFFF0A113, OP_SLTI,  1'b0, 1'b0, 5'd2,  5'd1,  5'd31, 32'hFFFFFFFF, 4'd8},
    '{32'h00003013, OP_SLTIU, 1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00004013, OP_XORI,  1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00006013, OP_ORI,   1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00007013, OP_ANDI,  1'b0, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00001013, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00005013, OP_JAL,   1'b1, 1'b1, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd6},
    '{32'h00000033, OP_JAL,   1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd7},  // R7
    '{32'h00000063, OP_JAL,   1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd7},
    '{32'h00000037, OP_JAL,   1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd7},
    '{32'h00000073, OP_JAL,   1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd7},
    '{32'hFFFFFFFF, OP_JAL,   1'b1, 1'b0, 5'd31, 5'd31, 5'd31, 32'h00000000, 4'd11}, // R11
    '{32'h0000006C, OP_JAL,   1'b1, 1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000, 4'd7}
  };

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    @(negedge clk);
  endtask

  initial begin
    instr = 32'h0;
    repeat (3) @(posedge clk);
    // reset state: all-zero word is an unknown opcode (R7, R11)
    @(negedge clk);
    check("R7", "illegal", {31'd0, ill}, 32'd1);
    check("R7", "cause", {31'd0, cause}, 32'd0);
    check("R11", "imm", imm, 32'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      apply(VECS[i].w);
      rq = $sformatf("R%0d", VECS[i].req);
      check(rq, "illegal", {31'd0, ill}, {31'd0, VECS[i].ill});
      if (VECS[i].ill) check(rq, "cause", {31'd0, cause}, {31'd0, VECS[i].cause});
      else             check(rq, "op", {28'd0, op}, {28'd0, VECS[i].op});
      check("R1", "rd",  {27'd0, rd},  {27'd0, VECS[i].rd});
      check("R1", "rs1", {27'd0, rs1}, {27'd0, VECS[i].rs1});
      check("R1", "rs2", {27'd0, rs2}, {27'd0, VECS[i].rs2});
      check(rq, "imm", imm, VECS[i].imm);
    end

    // R1/R8: single bit walked across the fields of an ADDI word
    for (int b = 7; b < 32; b++) begin
      if (b >= 12 && b <= 14) continue;
      apply(32'h00000013 | (32'd1 << b));
      check("R1", "rd",  {27'd0, rd},  (b >= 7  && b <= 11) ? 32'd1 << (b - 7)  : 32'd0);
      check("R1", "rs1", {27'd0, rs1}, (b >= 15 && b <= 19) ? 32'd1 << (b - 15) : 32'd0);
      check("R1", "rs2", {27'd0, rs2}, (b >= 20 && b <= 24) ? 32'd1 << (b - 20) : 32'd0);
      check("R8", "imm", imm, (b == 31) ? 32'hFFFFF800 :
                              (b >= 20) ? 32'd1 << (b - 20) : 32'd0);
    end

    // R10: each J-immediate slice lands at its own place
    for (int b = 12; b < 31; b++) begin
      logic [31:0] e;
      apply(32'h0000006F | (32'd1 << b));
      if (b <= 19)      e = 32'd1 << b;
      else if (b == 20) e = 32'd1 << 11;
      else              e = 32'd1 << (b - 20);
      check("R10", "imm", imm, e);
    end

    // R2: JAL ignores funct3
    for (int f = 0; f < 8; f++) begin
      apply(32'h000000EF | (32'(f) << 12));
      check("R2", "illegal", {31'd0, ill}, 32'd0);
      check("R2", "op", {28'd0, op}, 32'(OP_JAL));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule